// File: doc/BRIEF.md
# 64-bit Rotate-and-Mask Execution Unit

This unit executes six doubleword rotate instructions that share one primary opcode. Each instruction rotates a 64-bit source value left, then keeps or discards bit ranges through a mask. The mask is built from a 6-bit boundary and, for some forms, from the shift count. Four masking styles are offered: clear the bits left of a boundary, clear the bits right of a boundary, clear both sides with the right edge tied to the shift, and insert the rotated bits into the old destination value under that same two-sided mask.

Both the boundary and the immediate shift are 6-bit values whose top bit sits apart from the other five bits in the instruction word. Decoding must gather the correct bits. Two of the forms take the shift count from a register operand instead of the instruction. The unit registers its outputs once, so a result appears one cycle after the instruction is issued. The outputs are the result, a write-enable, an illegal-encoding flag, the record bit, and sign and zero indications that a condition-register stage outside the unit can use.

Top module: `rotmask64_unit`

## Requirements
- R1: When `valid_i` is high and instruction bits [31:26] are not 30, the next cycle shows `illegal_o`=1, `wr_en_o`=0 and `result_o`=0.
- R2: The mask boundary is {instr[5], instr[10:6]}. Bit 1 never takes part in it.
- R3: Immediate forms use the shift {instr[1], instr[15:11]}.
- R4: Register-shift forms use `shreg_i[5:0]` as the shift. Bits 63:6 of `shreg_i` have no effect on the result.
- R5: Clear-left form: result = rotl(src, sh) & (all-ones >> mb), where bit 63 is the most significant.
- R6: Clear-right form: result = rotl(src, sh) & ~(all-ones >> (me+1)). A boundary of 63 keeps every bit.
- R7: Clear-both form: mask = leftmask(mb) & rightmask(63 - sh).
- R8: Insert form: result = (rotl(src, sh) & mask) | (dst_old & ~mask), with the clear-both mask. Destination bits outside the mask are kept.
- R9: Extended opcode decoding. Bits [4:2] set to 0, 1, 2 or 3 select immediate clear-left, clear-right, clear-both or insert. Bits [4:1] set to 8 or 9 select register clear-left or register clear-right. Bits [4:2] set to 5, 6 or 7 are illegal: `illegal_o`=1, `wr_en_o`=0, result 0.
- R10: `record_o` equals instr[0]. `neg_o` equals result bit 63. `zero_o` is 1 exactly when the result is 0.
- R11: All outputs are registered with a latency of one cycle. `valid_o` follows `valid_i`, and `wr_en_o` = `valid_o` & ~`illegal_o`. After reset, every output is 0.
- R12: Immediate clear-left with sh=0 and mb=32 zero-extends the low word. For example, 64'hDEAD_BEEF_CAFE_BABE gives 64'h0000_0000_CAFE_BABE.
- R13: A rotate by 0 with a full mask returns the source unchanged. A rotate by 63 equals a rotate right by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction issued this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | 64 | Source register value |
| dst_old_i | input | 64 | Current destination value (insert form) |
| shreg_i | input | 64 | Shift register operand (register forms) |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Rotated and masked result |
| wr_en_o | output | 1 | Destination write enable |
| illegal_o | output | 1 | Encoding not recognised |
| record_o | output | 1 | Record bit copied from the instruction |
| neg_o | output | 1 | Result bit 63 |
| zero_o | output | 1 | Result equals zero |

## Verification
The bench targets the split fields first. A boundary of 32 only sets the separated top bit, so a decoder that reads bit 1 instead leaves the word untouched rather than zero-extending it. A shift of 32 with boundary 0 catches the reverse swap, where the shift bit would wrongly shorten the mask. Shift 0 and shift 63 expose rotate edge errors: a bad rotator would lose the source or rotate the wrong way. Boundary 63 on the right mask exposes an off-by-one that would drop bit 63. The sweep covers every shift and boundary value on all six forms. Register operands with garbage in the upper bits, unused extended opcodes and a foreign primary opcode check that decoding neither leaks stray bits nor writes on a bad encoding.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

    localparam int DW = 64;
    localparam int SW = $clog2(DW);
    localparam logic [5:0] PRIMARY_OP = 6'd30;

    // Extended opcode values
    localparam logic [2:0] XO_IMM_LEFT  = 3'd0;
    localparam logic [2:0] XO_IMM_RIGHT = 3'd1;
    localparam logic [2:0] XO_IMM_BOTH  = 3'd2;
    localparam logic [2:0] XO_IMM_INS   = 3'd3;
    localparam logic [2:0] XO_REG_GROUP = 3'd4;

    typedef enum logic [1:0] {
        MS_LEFT   = 2'd0,
        MS_RIGHT  = 2'd1,
        MS_BOTH   = 2'd2,
        MS_INSERT = 2'd3
    } mask_style_e;

    typedef struct packed {
        logic          illegal;
        mask_style_e   style;
        logic [SW-1:0] sh;
        logic [SW-1:0] bnd;
        logic          rec;
    } dec_t;

    typedef struct packed {
        logic          valid;
        logic          wr_en;
        logic          illegal;
        logic          rec;
        logic          neg;
        logic          zero;
        logic [DW-1:0] result;
    } out_t;

endpackage

// File: rtl/rotmask_decode.sv
module rotmask_decode
    import rotmask_pkg::*;
#(
    parameter int SHW = SW
) (
    input  logic [31:0]    instr_i,
    input  logic [SHW-1:0] shreg_lo_i,
    output dec_t           dec_o
);

    logic        prim_hit;
    logic [2:0]  xo3;
    logic        unused_regfields;

    assign prim_hit         = (instr_i[31:26] == PRIMARY_OP);
    assign xo3              = instr_i[4:2];
    assign unused_regfields = ^instr_i[25:16];

    always_comb begin
        dec_o         = '0;
        dec_o.rec     = instr_i[0];
        // boundary: top bit separated from the low five
        dec_o.bnd     = {instr_i[5], instr_i[10:6]};
        // immediate shift: top bit sits at bit 1
        dec_o.sh      = {instr_i[1], instr_i[15:11]};
        dec_o.style   = MS_LEFT;
        dec_o.illegal = 1'b1;
        if (prim_hit) begin
            case (xo3)
                XO_IMM_LEFT:  begin dec_o.style = MS_LEFT;   dec_o.illegal = 1'b0; end
                XO_IMM_RIGHT: begin dec_o.style = MS_RIGHT;  dec_o.illegal = 1'b0; end
                XO_IMM_BOTH:  begin dec_o.style = MS_BOTH;   dec_o.illegal = 1'b0; end
                XO_IMM_INS:   begin dec_o.style = MS_INSERT; dec_o.illegal = 1'b0; end
                XO_REG_GROUP: begin
                    dec_o.sh      = shreg_lo_i;
                    dec_o.style   = instr_i[1] ? MS_RIGHT : MS_LEFT;
                    dec_o.illegal = 1'b0;
                end
                default: dec_o.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen
    import rotmask_pkg::*;
#(
    parameter int MW  = DW,
    parameter int MSW = $clog2(MW)
) (
    input  mask_style_e    style_i,
    input  logic [MSW-1:0] sh_i,
    input  logic [MSW-1:0] bnd_i,
    output logic [MW-1:0]  mask_o
);

    localparam logic [MW-1:0]  ONES = '1;
    localparam logic [MSW-1:0] TOP  = MSW'(MW - 1);

    logic [MW-1:0]  left_m;
    logic [MW-1:0]  right_bnd_m;
    logic [MW-1:0]  right_sh_m;
    logic [MSW-1:0] me_from_sh;

    // keeps bits [e .. 0] counted from the MSB side; e = TOP yields all ones
    function automatic logic [MW-1:0] right_keep(input logic [MSW-1:0] e);
        logic [MSW:0] amt;
        amt = {1'b0, e} + 1'b1;
        return ~(ONES >> amt);
    endfunction

    assign me_from_sh  = TOP - sh_i;
    assign left_m      = ONES >> bnd_i;
    assign right_bnd_m = right_keep(bnd_i);
    assign right_sh_m  = right_keep(me_from_sh);

    always_comb begin
        case (style_i)
            MS_LEFT:  mask_o = left_m;
            MS_RIGHT: mask_o = right_bnd_m;
            default:  mask_o = left_m & right_sh_m;
        endcase
    end

endmodule

// File: rtl/rotmask_datapath.sv
module rotmask_datapath
    import rotmask_pkg::*;
#(
    parameter int PW  = DW,
    parameter int PSW = $clog2(PW)
) (
    input  logic [PW-1:0]  src_i,
    input  logic [PW-1:0]  dst_old_i,
    input  logic [PSW-1:0] sh_i,
    input  logic [PW-1:0]  mask_i,
    input  logic           insert_i,
    output logic [PW-1:0]  res_o
);

    logic [2*PW-1:0] doubled;
    logic [PW-1:0]   rotated;
    logic [PW-1:0]   kept;

    assign doubled = {src_i, src_i} << sh_i;
    assign rotated = doubled[2*PW-1:PW];
    assign kept    = rotated & mask_i;
    assign res_o   = insert_i ? (kept | (dst_old_i & ~mask_i)) : kept;

endmodule

// File: rtl/rotmask64_unit.sv
module rotmask64_unit
    import rotmask_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [31:0]   instr_i,
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] dst_old_i,
    input  logic [DW-1:0] shreg_i,
    output logic          valid_o,
    output logic [DW-1:0] result_o,
    output logic          wr_en_o,
    output logic          illegal_o,
    output logic          record_o,
    output logic          neg_o,
    output logic          zero_o
);

    dec_t          dec_w;
    logic [DW-1:0] mask_w;
    logic [DW-1:0] res_w;
    out_t          out_d, out_q;
    logic          unused_shreg_hi;
    logic          seen_d, seen_q;

    assign unused_shreg_hi = ^shreg_i[DW-1:SW];

    rotmask_decode #(.SHW(SW)) u_dec (
        .instr_i    (instr_i),
        .shreg_lo_i (shreg_i[SW-1:0]),
        .dec_o      (dec_w)
    );

    rotmask_maskgen #(.MW(DW), .MSW(SW)) u_mask (
        .style_i (dec_w.style),
        .sh_i    (dec_w.sh),
        .bnd_i   (dec_w.bnd),
        .mask_o  (mask_w)
    );

    rotmask_datapath #(.PW(DW), .PSW(SW)) u_dp (
        .src_i     (src_i),
        .dst_old_i (dst_old_i),
        .sh_i      (dec_w.sh),
        .mask_i    (mask_w),
        .insert_i  (dec_w.style == MS_INSERT),
        .res_o     (res_w)
    );

    always_comb begin
        out_d         = '0;
        out_d.valid   = valid_i;
        out_d.illegal = valid_i & dec_w.illegal;
        out_d.wr_en   = valid_i & ~dec_w.illegal;
        out_d.rec     = valid_i & dec_w.rec;
        out_d.result  = (valid_i && !dec_w.illegal) ? res_w : '0;
        out_d.neg     = out_d.result[DW-1];
        out_d.zero    = (out_d.result == '0);
        seen_d        = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            seen_q <= seen_d;
        end
    end

    assign valid_o   = out_q.valid;
    assign result_o  = out_q.result;
    assign wr_en_o   = out_q.wr_en;
    assign illegal_o = out_q.illegal;
    assign record_o  = out_q.rec;
    assign neg_o     = out_q.neg;
    assign zero_o    = out_q.zero;

    // R11: one-cycle latency on the valid flag
    a_r11_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (valid_o == $past(valid_i)));

    // R1: a foreign primary opcode never writes
    a_r1_foreign_op: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[31:26] != PRIMARY_OP) |=> (illegal_o && !wr_en_o));

    // R10: record bit carried through
    a_r10_record: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (record_o == $past(instr_i[0])));

    // R8: insert keeps destination bits outside the mask
    a_r8_insert_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dec_w.illegal && dec_w.style == MS_INSERT)
        |-> (((res_w ^ dst_old_i) & ~mask_w) == '0));

    // R5: clearing forms leave nothing outside the mask
    a_r5_outside_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dec_w.illegal && dec_w.style != MS_INSERT)
        |-> ((res_w & ~mask_w) == '0));

    // R9: illegal encodings never carry a write enable
    a_r9_no_write_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wr_en_o);

endmodule

// File: tb/tb_rotmask64_unit.sv
`timescale 1ns/100ps
module tb_rotmask64_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] src_i = '0, dst_old_i = '0, shreg_i = '0;
    logic        valid_o, wr_en_o, illegal_o, record_o, neg_o, zero_o;
    logic [63:0] result_o;

    always #2.5 clk = ~clk;

    rotmask64_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .src_i(src_i), .dst_old_i(dst_old_i), .shreg_i(shreg_i),
        .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o),
        .illegal_o(illegal_o), .record_o(record_o), .neg_o(neg_o), .zero_o(zero_o)
    );

    typedef struct {
        logic [63:0] res;
        logic        ill;
        logic        rec;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    function automatic logic [63:0] rotl(input logic [63:0] x, input int s);
        if (s == 0) return x;
        return (x << s) | (x >> (64 - s));
    endfunction

    function automatic logic [63:0] lmask(input int mb);
        return 64'hFFFF_FFFF_FFFF_FFFF >> mb;
    endfunction

    function automatic logic [63:0] rmask(input int me);
        if (me == 63) return 64'hFFFF_FFFF_FFFF_FFFF;
        return ~(64'hFFFF_FFFF_FFFF_FFFF >> (me + 1));
    endfunction

    function automatic logic [31:0] enc_imm(input int xo, input int sh, input int mb, input bit rc);
        logic [5:0] s6, m6;
        logic [2:0] x3;
        s6 = sh[5:0]; m6 = mb[5:0]; x3 = xo[2:0];
        return {6'd30, 5'd4, 5'd3, s6[4:0], m6[4:0], m6[5], x3, s6[5], rc};
    endfunction

    function automatic logic [31:0] enc_reg(input bit right, input int mb, input bit rc);
        logic [5:0] m6;
        m6 = mb[5:0];
        return {6'd30, 5'd4, 5'd3, 5'd7, m6[4:0], m6[5], 3'b100, right, rc};
    endfunction

    // behavioural model built from the requirement formulas
    function automatic void model(input logic [31:0] ins, input logic [63:0] s,
                                  input logic [63:0] d, input logic [63:0] r,
                                  output logic [63:0] res, output bit ill);
        int sh, mb;
        logic [63:0] m, rot;
        res = '0; ill = 1'b0;
        mb  = {ins[5], ins[10:6]};
        sh  = {ins[1], ins[15:11]};
        if (ins[31:26] != 6'd30) begin ill = 1'b1; return; end
        case (ins[4:2])
            3'd0: res = rotl(s, sh) & lmask(mb);
            3'd1: res = rotl(s, sh) & rmask(mb);
            3'd2: res = rotl(s, sh) & lmask(mb) & rmask(63 - sh);
            3'd3: begin
                m   = lmask(mb) & rmask(63 - sh);
                res = (rotl(s, sh) & m) | (d & ~m);
            end
            3'd4: begin
                rot = rotl(s, int'(r[5:0]));
                res = ins[1] ? (rot & rmask(mb)) : (rot & lmask(mb));
            end
            default: ill = 1'b1;
        endcase
    endfunction

    task automatic issue_x(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] d,
                           input logic [63:0] r, input logic [63:0] eres, input bit eill,
                           input string tag);
        exp_t e;
        @(negedge clk);
        valid_i = 1'b1; instr_i = ins; src_i = s; dst_old_i = d; shreg_i = r;
        e.res = eill ? 64'd0 : eres; e.ill = eill; e.rec = ins[0]; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic issue(input logic [31:0] ins, input logic [63:0] s, input logic [63:0] d,
                         input logic [63:0] r, input string tag);
        logic [63:0] er;
        bit ei;
        model(ins, s, d, r, er, ei);
        issue_x(ins, s, d, r, er, ei, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a result is presented
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R11 unexpected valid_o", result_o, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(result_o == e.res && illegal_o == e.ill && wr_en_o == !e.ill &&
                      record_o == e.rec && neg_o == e.res[63] && zero_o == (e.res == 64'd0),
                      {e.tag, " result/flags"}, result_o, e.res);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 64'd0, 64'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, c;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && result_o == 64'd0 && wr_en_o == 1'b0 && illegal_o == 1'b0 &&
              record_o == 1'b0 && neg_o == 1'b0 && zero_o == 1'b0, "R11 reset state", result_o, 64'd0);
        rst_n = 1'b1;
        idle(2);
        check(valid_o == 1'b0 && wr_en_o == 1'b0, "R11 idle after reset", {63'd0, valid_o}, 64'd0);

        // R12: zero-extension idiom
        issue_x(enc_imm(0, 0, 32, 0), 64'hDEAD_BEEF_CAFE_BABE, 64'd0, 64'd0,
                64'h0000_0000_CAFE_BABE, 1'b0, "R12");
        issue_x(enc_imm(0, 0, 32, 0), 64'hFFFF_FFFF_1234_5678, 64'd0, 64'd0,
                64'h0000_0000_1234_5678, 1'b0, "R12");
        // R13: rotate by 0 and by 63
        a = 64'h8123_4567_89AB_CDEF;
        issue_x(enc_imm(0, 0, 0, 0), a, 64'd0, 64'd0, a, 1'b0, "R13 rot0");
        issue_x(enc_imm(0, 63, 0, 0), a, 64'd0, 64'd0, {a[0], a[63:1]}, 1'b0, "R13 rot63");
        // R2/R3: shift 32 sets bit 1 only; boundary must stay 0
        issue_x(enc_imm(0, 32, 0, 0), a, 64'd0, 64'd0, {a[31:0], a[63:32]}, 1'b0, "R2 R3 bit1");
        // R4: register shift ignores upper bits of the operand
        issue_x(enc_reg(1'b0, 0, 0), a, 64'd0, 64'hFFFF_FFFF_FFFF_FFC4,
                {a[59:0], a[63:60]}, 1'b0, "R4 upper ignored");
        // R6: boundary 63 keeps everything
        issue_x(enc_imm(1, 0, 63, 0), a, 64'd0, 64'd0, a, 1'b0, "R6 me63");
        // R7: clear-both sh=8 mb=16 keeps bits 16..55 (MSB numbering)
        issue_x(enc_imm(2, 8, 16, 0), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0,
                64'h0000_FFFF_FFFF_FF00, 1'b0, "R7");
        // R8: insert under the same mask keeps the rest of the destination
        issue_x(enc_imm(3, 8, 16, 0), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,
                64'hFFFF_0000_0000_00FF, 1'b0, "R8");
        // R1: foreign primary opcode
        b = enc_imm(0, 5, 5, 0); b[31:26] = 6'd31;
        issue_x(b, a, 64'd0, 64'd0, 64'd0, 1'b1, "R1 foreign op");
        // R9: unused extended opcodes
        for (int x = 5; x < 8; x++) issue_x(enc_imm(x, 1, 1, 0), a, 64'd0, 64'd0, 64'd0, 1'b1, "R9 bad xo");
        // R10: record, negative and zero indications
        issue_x(enc_imm(0, 0, 0, 1), a, 64'd0, 64'd0, a, 1'b0, "R10 rec neg");
        issue_x(enc_imm(0, 0, 32, 1), 64'hFFFF_FFFF_0000_0000, 64'd0, 64'd0, 64'd0, 1'b0, "R10 zero");
        idle(3);
        check(valid_o == 1'b0 && wr_en_o == 1'b0, "R11 bubble", {63'd0, valid_o}, 64'd0);

        // full sweep: every shift and boundary for every form
        for (int op = 0; op < 6; op++) begin
            for (int sh = 0; sh < 64; sh++) begin
                for (int mb = 0; mb < 64; mb++) begin
                    a = {$urandom, $urandom};
                    b = {$urandom, $urandom};
                    c = {$urandom, $urandom};
                    c[5:0] = sh[5:0];
                    case (op)
                        0: issue(enc_imm(0, sh, mb, mb[0]), a, b, c, "R5 sweep");
                        1: issue(enc_imm(1, sh, mb, mb[0]), a, b, c, "R6 sweep");
                        2: issue(enc_imm(2, sh, mb, mb[0]), a, b, c, "R7 sweep");
                        3: issue(enc_imm(3, sh, mb, mb[0]), a, b, c, "R8 sweep");
                        4: issue(enc_reg(1'b0, mb, mb[0]), a, b, c, "R4 R5 reg sweep");
                        default: issue(enc_reg(1'b1, mb, mb[0]), a, b, c, "R4 R6 reg sweep");
                    endcase
                end
            end
        end
        idle(4);
        check(q.size() == 0, "R11 scoreboard drained", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule